// File: doc/BRIEF.md
# SMM Soft-Reset and Address-Wrap Guard

This block sits between the system's reset and A20-mask sources and the processor pins. While the processor is handling a system-management interrupt, it holds back the soft reset and forces the address-bit-20 mask off. A soft reset that arrives while it is held back is not lost. It is remembered and then delivered as one fixed-width pulse once it is safe to do so. The hard reset is never touched and passes straight through.

The hold on soft reset starts in the same cycle that the interrupt request is raised, before the processor reports that it is in management mode. The hold ends at whichever of two events comes first: a fixed number of clocks after the management-mode indication drops, or the start of the next bus cycle. The A20 mask output is forced low while the management-mode indication is high. Once that indication drops, the output simply follows whatever level the system requests.

Top module: `smm_rst_guard`

## Requirements
- R1: In any cycle where `smi_req` is 1, `cpu_srst` is 0 in that same cycle, unless a released pulse (R4) is already under way.
- R2: After `smm_active` goes from 1 to 0 (first low cycle t), `srst_req` stays held back for cycles t through t+EXIT_HOLD-1 (EXIT_HOLD defaults to 20). From cycle t+EXIT_HOLD onward it is no longer held back.
- R3: A `bus_start` of 1 while the post-exit count is running ends the hold in that same cycle.
- R4: A `srst_req` seen while the hold is active is remembered. Once the hold ends in cycle u, `cpu_srst` is 1 for exactly PULSE_W cycles (default 4), from u+1 to u+PULSE_W.
- R5: When no hold is active and no pulse is running, `cpu_srst` equals `srst_req` in the same cycle.
- R6: `cpu_rst` equals `rst_hard` in the same cycle in every state, including during management mode.
- R7: `rst_hard` clears any remembered soft reset and the post-exit count. After it is released, no pulse appears, and `srst_req` passes through at once.
- R8: While `smm_active` is 1, `cpu_a20` is 0 whatever `a20_req` is.
- R9: While `smm_active` is 0, `cpu_a20` equals `a20_req` in the same cycle. This includes a level that changed during management mode.
- R10: Once a released pulse has started, a new `smi_req` or `smm_active` does not shorten it: `cpu_srst` stays 1 for all PULSE_W cycles.
- R11: A new `smi_req` during the post-exit count keeps the hold active without a gap. The count restarts when `smm_active` next falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_hard | input | 1 | Hard system reset, active high; also resets the block asynchronously |
| smi_req | input | 1 | Management interrupt request to the processor, active high |
| smm_active | input | 1 | Processor indication that it is in management mode, active high |
| bus_start | input | 1 | Strobe marking the first cycle of a processor bus cycle |
| srst_req | input | 1 | Raw soft-reset request from the system |
| a20_req | input | 1 | Raw A20 mask request from the system |
| cpu_rst | output | 1 | Hard reset to the processor |
| cpu_srst | output | 1 | Guarded soft reset to the processor |
| cpu_a20 | output | 1 | Guarded A20 mask to the processor |

## Verification
Two functions can fall in the same cycle: the delivery of a remembered soft reset and the start of a new hold. The bench releases a latched request using a bus-cycle strobe. It then raises a new interrupt, and after that the management-mode indication, in the second and third cycles of the released pulse. It expects `cpu_srst` to stay high for the full pulse width and to drop only once the pulse has ended. A second collision, where a bus-cycle strobe ends the post-exit count early, is judged by checking that the pulse starts exactly one cycle after the strobe.

// File: rtl/smm_guard_pkg.sv
package smm_guard_pkg;

  // Next value of the post-exit hold counter.
  function automatic int hold_next(int cur, bit load, bit clear, int hold);
    if (load)          return hold;
    else if (clear)    return 0;
    else if (cur > 0)  return cur - 1;
    else               return 0;
  endfunction

  // Next value of the release-pulse counter.
  function automatic int pulse_next(int cur, bit fire, int width);
    if (fire)          return width;
    else if (cur > 0)  return cur - 1;
    else               return 0;
  endfunction

endpackage

// File: rtl/smm_exit_window.sv
module smm_exit_window
  import smm_guard_pkg::*;
#(
  parameter int EXIT_HOLD = 20
) (
  input  logic clk,
  input  logic rst_hard,
  input  logic smi_req,
  input  logic smm_active,
  input  logic bus_start,
  output logic blocked,
  output logic win_busy
);
  localparam int CW = $clog2(EXIT_HOLD + 1);

  logic [CW-1:0] cnt_q;
  logic          act_d_q;

  assign win_busy = (cnt_q != '0);
  assign blocked  = smi_req | smm_active | (win_busy & ~bus_start);

  always_ff @(posedge clk or posedge rst_hard) begin
    if (rst_hard) begin
      cnt_q   <= '0;
      act_d_q <= 1'b0;
    end else begin
      cnt_q   <= CW'(hold_next(int'(cnt_q), smi_req | smm_active, bus_start, EXIT_HOLD));
      act_d_q <= smm_active;
    end
  end

  // R2: the count is running in the first cycle after management mode ends
  p_exit_hold_armed_r2: assert property (@(posedge clk) disable iff (rst_hard)
    (act_d_q && !smm_active && !smi_req) |-> win_busy);

  // R11: an interrupt during the count keeps the hold active into the next cycle
  p_rearm_no_gap_r11: assert property (@(posedge clk) disable iff (rst_hard)
    (win_busy && smi_req) |=> win_busy);

endmodule

// File: rtl/srst_release.sv
module srst_release
  import smm_guard_pkg::*;
#(
  parameter int PULSE_W = 4
) (
  input  logic clk,
  input  logic rst_hard,
  input  logic blocked,
  input  logic srst_req,
  output logic srst_out,
  output logic pend,
  output logic pulse_on
);
  localparam int PW = $clog2(PULSE_W + 1);

  logic [PW-1:0] pcnt_q;
  logic          pend_q;
  logic          fire;

  assign pulse_on = (pcnt_q != '0);
  assign pend     = pend_q;
  assign fire     = ~blocked & pend_q & ~pulse_on;
  assign srst_out = pulse_on | (srst_req & ~blocked);

  always_ff @(posedge clk or posedge rst_hard) begin
    if (rst_hard) begin
      pend_q <= 1'b0;
      pcnt_q <= '0;
    end else begin
      if (srst_req && blocked) pend_q <= 1'b1;
      else if (fire)           pend_q <= 1'b0;
      pcnt_q <= PW'(pulse_next(int'(pcnt_q), fire, PULSE_W));
    end
  end

  // R4: a held-back request is remembered or is already being delivered
  p_latch_request_r4: assert property (@(posedge clk) disable iff (rst_hard)
    (srst_req && blocked) |=> (pend || pulse_on));

  // R10: an issued pulse always reaches the pin, blocked or not
  p_pulse_uncut_r10: assert property (@(posedge clk) disable iff (rst_hard)
    pulse_on |-> srst_out);

  // R4: a pulse lasts more than one cycle once started
  generate
    if (PULSE_W > 1) begin : g_width
      p_pulse_width_r4: assert property (@(posedge clk) disable iff (rst_hard)
        $rose(pulse_on) |=> pulse_on);
    end
  endgenerate

endmodule

// File: rtl/a20_gate.sv
module a20_gate (
  input  logic smm_active,
  input  logic a20_req,
  output logic a20_out
);
  assign a20_out = a20_req & ~smm_active;
endmodule

// File: rtl/smm_rst_guard.sv
module smm_rst_guard #(
  parameter int EXIT_HOLD = 20,
  parameter int PULSE_W   = 4
) (
  input  logic clk,
  input  logic rst_hard,
  input  logic smi_req,
  input  logic smm_active,
  input  logic bus_start,
  input  logic srst_req,
  input  logic a20_req,
  output logic cpu_rst,
  output logic cpu_srst,
  output logic cpu_a20
);
  logic blocked;
  logic win_busy;
  logic pend;
  logic pulse_on;

  assign cpu_rst = rst_hard;

  smm_exit_window #(.EXIT_HOLD(EXIT_HOLD)) win_i (
    .clk        (clk),
    .rst_hard   (rst_hard),
    .smi_req    (smi_req),
    .smm_active (smm_active),
    .bus_start  (bus_start),
    .blocked    (blocked),
    .win_busy   (win_busy)
  );

  srst_release #(.PULSE_W(PULSE_W)) rel_i (
    .clk      (clk),
    .rst_hard (rst_hard),
    .blocked  (blocked),
    .srst_req (srst_req),
    .srst_out (cpu_srst),
    .pend     (pend),
    .pulse_on (pulse_on)
  );

  a20_gate a20_i (
    .smm_active (smm_active),
    .a20_req    (a20_req),
    .a20_out    (cpu_a20)
  );

  // R1: an interrupt request silences the soft reset unless a pulse is in flight
  p_smi_blocks_r1: assert property (@(posedge clk) disable iff (rst_hard)
    (smi_req && !pulse_on) |-> !cpu_srst);

  // R8: the A20 mask never reaches the processor during management mode
  p_a20_forced_r8: assert property (@(posedge clk) disable iff (rst_hard)
    smm_active |-> !cpu_a20);

  // R5: with no hold, no pulse and no memory, the request passes unchanged
  p_passthrough_r5: assert property (@(posedge clk) disable iff (rst_hard)
    (!smi_req && !smm_active && !win_busy && !pulse_on && !pend) |-> (cpu_srst == srst_req));

endmodule

// File: tb/smm_rst_guard_tb.sv
module smm_rst_guard_tb_top;
  logic clk = 1'b0;
  logic rst_hard = 1'b1;
  logic smi_req = 1'b0, smm_active = 1'b0, bus_start = 1'b0;
  logic srst_req = 1'b0, a20_req = 1'b0;
  logic cpu_rst, cpu_srst, cpu_a20;

  smm_rst_guard dut_i (
    .clk(clk), .rst_hard(rst_hard), .smi_req(smi_req), .smm_active(smm_active),
    .bus_start(bus_start), .srst_req(srst_req), .a20_req(a20_req),
    .cpu_rst(cpu_rst), .cpu_srst(cpu_srst), .cpu_a20(cpu_a20)
  );

  always #5 clk = ~clk;

  typedef struct {
    int    cyc;
    logic  srst;
    logic  a20;
    logic  rst;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare queued expectations at the falling edge of their cycle
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (e.cyc != cyc || cpu_srst !== e.srst || cpu_a20 !== e.a20 || cpu_rst !== e.rst) begin
        n_fail++;
        $display("FAIL %s cycle %0d: got srst=%b a20=%b rst=%b, expected srst=%b a20=%b rst=%b",
                 e.tag, e.cyc, cpu_srst, cpu_a20, cpu_rst, e.srst, e.a20, e.rst);
      end
    end
  end

  // Driver: apply inputs just after a rising edge
  task automatic drv(input logic s, input logic a, input logic b, input logic r, input logic m);
    @(posedge clk);
    #1;
    smi_req = s; smm_active = a; bus_start = b; srst_req = r; a20_req = m;
  endtask

  task automatic chk(input string tag, input logic es, input logic ea, input logic er);
    exp_t e;
    e.cyc = cyc; e.srst = es; e.a20 = ea; e.rst = er; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got no finish, expected finish");
    finish_run();
  end

  initial begin
    // reset state and hard reset pass-through (R6)
    drv(0,0,0,0,0); chk("R6", 0, 0, 1);
    drv(0,0,0,0,0); chk("R6", 0, 0, 1);
    drv(0,0,0,0,0); rst_hard = 1'b0; chk("R6", 0, 0, 0);

    // R5 and R9 pass-through outside management mode
    drv(0,0,0,1,1); chk("R5", 1, 1, 0);
    drv(0,0,0,0,0); chk("R5", 0, 0, 0);
    drv(0,0,0,0,1); chk("R9", 0, 1, 0);

    // Scenario: request with SMI, full post-exit count
    drv(1,0,0,1,1); chk("R1", 0, 1, 0);
    for (int i = 0; i < 3; i++) begin drv(0,1,0,0,1); chk("R8", 0, 0, 0); end
    for (int i = 0; i < 20; i++) begin drv(0,0,0,0,1); chk("R2", 0, 1, 0); end
    drv(0,0,0,0,1); chk("R2", 0, 1, 0);
    for (int i = 0; i < 4; i++) begin drv(0,0,0,0,1); chk("R4", 1, 1, 0); end
    drv(0,0,0,0,1); chk("R4", 0, 1, 0);

    // Scenario: bus-cycle start cuts the count short; A20 level changed during SMM
    drv(1,0,0,0,0); chk("R1", 0, 0, 0);
    for (int i = 0; i < 2; i++) begin drv(0,1,0,0,1); chk("R8", 0, 0, 0); end
    drv(0,0,0,1,1); chk("R9", 0, 1, 0);
    drv(0,0,0,0,1); chk("R2", 0, 1, 0);
    drv(0,0,1,0,1); chk("R3", 0, 1, 0);
    for (int i = 0; i < 4; i++) begin drv(0,0,0,0,1); chk("R3", 1, 1, 0); end
    drv(0,0,0,0,1); chk("R4", 0, 1, 0);

    // Scenario: pulse collides with a new SMI, then SMI again during the count
    drv(1,0,0,1,0); chk("R1", 0, 0, 0);
    drv(0,1,0,0,0); chk("R1", 0, 0, 0);
    drv(0,0,1,0,0); chk("R3", 0, 0, 0);
    drv(0,0,0,0,0); chk("R10", 1, 0, 0);
    drv(1,0,0,0,0); chk("R10", 1, 0, 0);
    drv(0,1,0,0,1); chk("R10", 1, 0, 0);
    drv(0,1,0,0,1); chk("R10", 1, 0, 0);
    drv(0,1,0,0,1); chk("R10", 0, 0, 0);
    for (int i = 0; i < 3; i++) begin drv(0,0,0,0,0); chk("R2", 0, 0, 0); end
    drv(1,0,0,1,0); chk("R11", 0, 0, 0);
    drv(0,1,0,0,0); chk("R11", 0, 0, 0);
    for (int i = 0; i < 20; i++) begin drv(0,0,0,0,0); chk("R11", 0, 0, 0); end
    drv(0,0,0,0,0); chk("R11", 0, 0, 0);
    for (int i = 0; i < 4; i++) begin drv(0,0,0,0,0); chk("R11", 1, 0, 0); end
    drv(0,0,0,0,0); chk("R11", 0, 0, 0);

    // Scenario: hard reset during management mode discards the latched request
    drv(1,0,0,1,0); chk("R1", 0, 0, 0);
    drv(0,1,0,0,1); chk("R8", 0, 0, 0);
    drv(0,1,0,0,1); rst_hard = 1'b1; chk("R6", 0, 0, 1);
    drv(0,0,0,0,0); chk("R6", 0, 0, 1);
    drv(0,0,0,0,0); rst_hard = 1'b0; chk("R7", 0, 0, 0);
    for (int i = 0; i < 25; i++) begin drv(0,0,0,0,0); chk("R7", 0, 0, 0); end
    drv(0,0,0,1,0); chk("R7", 1, 0, 0);
    drv(0,0,0,0,0); chk("R7", 0, 0, 0);

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL queue: got %0d pending, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule